// File: doc/BRIEF.md
# Quad-Precision Float Classifier

This block inspects a 128-bit binary128 floating-point operand and reports which of ten value classes it falls into, as a one-hot mask. The operand is split into a sign bit (bit 127), a 15-bit biased exponent (bits 126:112) and a 112-bit fraction (bits 111:0). The block checks whether the exponent is all ones or all zeros and whether the fraction is zero. For NaNs it also looks at the top fraction bit. From these it picks exactly one class.

The mask is registered and zero-extended to the integer register width (`XLEN`). The result appears, with `out_valid`, one clock after an operand is offered with `in_valid`. The block performs no arithmetic and no rounding. It has no exception-flag output, so classifying any value, including a signalling NaN, raises no flag.

Top module: `qfc_classify`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. While `rst_n` is low at a clock edge, `out_valid` and `out_mask` are cleared to zero.
- R2: Bits `XLEN-1` down to 10 of `out_mask` are always zero.
- R3: Whenever `out_valid` is high, exactly one of bits 9:0 of `out_mask` is set.
- R4: An all-ones exponent with a zero fraction is an infinity. It sets bit 0 when the sign is 1 and bit 7 when the sign is 0.
- R5: An exponent that is neither all zeros nor all ones is a normal number. It sets bit 1 for a negative sign and bit 6 for a positive sign.
- R6: An all-zeros exponent with a nonzero fraction is a subnormal. It sets bit 2 for a negative sign and bit 5 for a positive sign.
- R7: An all-zeros exponent with a zero fraction is a zero. It sets bit 3 for negative zero and bit 4 for positive zero.
- R8: An all-ones exponent with fraction bit 111 set is a quiet NaN. It sets bit 9 for either sign.
- R9: An all-ones exponent with fraction bit 111 clear and a nonzero fraction is a signalling NaN. It sets bit 8 for either sign, with no flag output or other side effect.
- R10: A clock edge with `in_valid` low leaves `out_mask` unchanged, whatever `in_operand` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 128 | binary128 operand: sign 127, exponent 126:112, fraction 111:0 |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_mask | output | XLEN | One-hot class mask in bits 9:0, upper bits zero |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid delay and the reset clearing;
- the zero upper bits;
- the single set bit;
- the hold of the mask on idle cycles;
- the NaN, zero and negative-infinity classes.

The exact bit for each of the ten classes is shown only by the bench's scenarios. These include both signs of every boundary value: the smallest and largest subnormals, the smallest and largest normals, the minimal signalling NaN payload, and the bare quiet NaN. Random operands are biased towards the special exponents. A reset in the middle of a run is also exercised only by the bench.

// File: rtl/qfc_pkg.sv
// Package: shared widths, class bit positions and decoded-field type
// for the quad-precision classifier.
package qfc_pkg;
    localparam int unsigned CLASS_N = 10;

    // Bit position of each class inside the result mask.
    typedef enum int unsigned {
        CLS_NEG_INF  = 0,
        CLS_NEG_NORM = 1,
        CLS_NEG_SUB  = 2,
        CLS_NEG_ZERO = 3,
        CLS_POS_ZERO = 4,
        CLS_POS_SUB  = 5,
        CLS_POS_NORM = 6,
        CLS_POS_INF  = 7,
        CLS_SNAN     = 8,
        CLS_QNAN     = 9
    } qfc_class_e;

    // Summary flags of the operand fields.
    typedef struct packed {
        logic sign;
        logic exp_ones;
        logic exp_zero;
        logic frac_zero;
        logic frac_msb;
    } qfc_fields_t;
endpackage

// File: rtl/qfc_field_split.sv
// Module: qfc_field_split
// Reduces a floating-point operand to the five facts the class decision
// needs. Assumes the layout sign | exponent | fraction, sign at the MSB.
module qfc_field_split
    import qfc_pkg::*;
#(
    parameter int unsigned EXP_W  = 15,
    parameter int unsigned FRAC_W = 112,
    localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [OP_W-1:0] op,
    output qfc_fields_t     fields
);
    logic [EXP_W-1:0]  exp_bits;
    logic [FRAC_W-1:0] frac_bits;

    assign exp_bits  = op[OP_W-2 -: EXP_W];
    assign frac_bits = op[FRAC_W-1:0];

    // Reduce the exponent and fraction to their summary flags.
    always_comb begin
        fields.sign      = op[OP_W-1];
        fields.exp_ones  = &exp_bits;
        fields.exp_zero  = ~|exp_bits;
        fields.frac_zero = ~|frac_bits;
        fields.frac_msb  = frac_bits[FRAC_W-1];
    end
endmodule

// File: rtl/qfc_class_encode.sv
// Module: qfc_class_encode
// Turns the field summary into a one-hot class mask. Pure combinational.
// Assumes the fields come from a well-formed split (flags consistent).
module qfc_class_encode
    import qfc_pkg::*;
(
    input  qfc_fields_t        fields,
    output logic [CLASS_N-1:0] mask
);
    // Choose exactly one class bit from exponent, fraction and sign.
    always_comb begin
        mask = '0;
        if (fields.exp_ones) begin
            if (fields.frac_zero)
                mask[fields.sign ? CLS_NEG_INF : CLS_POS_INF] = 1'b1;
            else if (fields.frac_msb)
                mask[CLS_QNAN] = 1'b1;
            else
                mask[CLS_SNAN] = 1'b1;
        end else if (fields.exp_zero) begin
            if (fields.frac_zero)
                mask[fields.sign ? CLS_NEG_ZERO : CLS_POS_ZERO] = 1'b1;
            else
                mask[fields.sign ? CLS_NEG_SUB : CLS_POS_SUB] = 1'b1;
        end else begin
            mask[fields.sign ? CLS_NEG_NORM : CLS_POS_NORM] = 1'b1;
        end
    end
endmodule

// File: rtl/qfc_out_stage.sv
// Module: qfc_out_stage
// Registers the class mask and the valid strobe, then zero-extends the
// mask to the integer width. Assumes XLEN >= CLASS_N.
module qfc_out_stage
    import qfc_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [CLASS_N-1:0] class_mask,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_word
);
    logic [CLASS_N-1:0] mask_q;

    // Capture a new mask only on accepted operands; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            mask_q    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                mask_q <= class_mask;
        end
    end

    // Zero-extend to the integer width when it is wider than the mask.
    generate
        if (XLEN > CLASS_N) begin : g_ext
            assign out_word = {{(XLEN-CLASS_N){1'b0}}, mask_q};
        end else begin : g_flat
            assign out_word = mask_q;
        end
    endgenerate
endmodule

// File: rtl/qfc_classify.sv
// Module: qfc_classify (top)
// Classifies a binary128 operand into a one-hot ten-class mask with one
// cycle of latency. Raises no exception flags. Assumes XLEN >= 10.
module qfc_classify
    import qfc_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned EXP_W  = 15,
    parameter int unsigned FRAC_W = 112,
    localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_operand,
    output logic            out_valid,
    output logic [XLEN-1:0] out_mask
);
    qfc_fields_t        fields;
    logic [CLASS_N-1:0] class_mask;

    qfc_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_split (
        .op     (in_operand),
        .fields (fields)
    );

    qfc_class_encode u_encode (
        .fields (fields),
        .mask   (class_mask)
    );

    qfc_out_stage #(.XLEN(XLEN)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .class_mask (class_mask),
        .out_valid  (out_valid),
        .out_word   (out_mask)
    );
endmodule

// File: rtl/qfc_classify_chk.sv
// Module: qfc_classify_chk
// Port-level properties of the classifier, bound to every instance.
module qfc_classify_chk #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned EXP_W  = 15,
    parameter int unsigned FRAC_W = 112,
    localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] in_operand,
    input logic            out_valid,
    input logic [XLEN-1:0] out_mask
);
    logic exp_ones, exp_zero, frac_zero, sgn;
    assign sgn       = in_operand[OP_W-1];
    assign exp_ones  = &in_operand[OP_W-2 -: EXP_W];
    assign exp_zero  = ~|in_operand[OP_W-2 -: EXP_W];
    assign frac_zero = ~|in_operand[FRAC_W-1:0];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R1
    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_mask[XLEN-1:10] == '0);  // R2
    AST_SINGLE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_mask[9:0]) == 1);  // R3
    AST_NEG_INF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exp_ones && frac_zero && sgn) |=> out_mask[0]);  // R4
    AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exp_zero && frac_zero) |=> (out_mask[3] || out_mask[4]));  // R7
    AST_NAN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exp_ones && !frac_zero) |=> (out_mask[8] || out_mask[9]));  // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_mask));  // R10
endmodule

bind qfc_classify qfc_classify_chk #(.XLEN(XLEN), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_mask   (out_mask)
);

// File: tb/sim_qfc_classify.sv
// Bench for qfc_classify: directed corners plus seeded random operands.
module sim_qfc_classify;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [127:0]    in_operand = '0;
    logic            out_valid;
    logic [XLEN-1:0] out_mask;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;
    logic [9:0] last_exp = '0;

    always #10 clk = ~clk;  // 50 MHz

    qfc_classify #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .out_valid(out_valid), .out_mask(out_mask)
    );

    function automatic logic [127:0] mk(input logic s, input logic [14:0] e, input logic [111:0] f);
        return {s, e, f};
    endfunction

    // Expected class from the requirement text.
    function automatic logic [9:0] ref_class(input logic [127:0] op);
        logic s = op[127];
        logic [14:0] e = op[126:112];
        logic [111:0] f = op[111:0];
        logic [9:0] m = '0;
        if (e == 15'h7fff) begin
            if (f == '0) m[s ? 0 : 7] = 1'b1;            // R4
            else if (f[111]) m[9] = 1'b1;               // R8
            else m[8] = 1'b1;                           // R9
        end else if (e == '0) begin
            if (f == '0) m[s ? 3 : 4] = 1'b1;            // R7
            else m[s ? 2 : 5] = 1'b1;                    // R6
        end else m[s ? 1 : 6] = 1'b1;                    // R5
        return m;
    endfunction

    function automatic string tag_of(input logic [9:0] m);
        if (m[0] || m[7]) return "R4";
        if (m[1] || m[6]) return "R5";
        if (m[2] || m[5]) return "R6";
        if (m[3] || m[4]) return "R7";
        if (m[9]) return "R8";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one operand, then check valid, class and upper bits.
    task automatic send(input logic [127:0] op);
        logic [9:0] e = ref_class(op);
        @(negedge clk);
        in_valid = 1'b1;
        in_operand = op;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", XLEN'(out_valid), XLEN'(1));
        check(tag_of(e), XLEN'(out_mask[9:0]), XLEN'(e));
        check("R2", out_mask >> 10, '0);
        check("R3", XLEN'($countones(out_mask[9:0])), XLEN'(1));
        last_exp = e;
    endtask

    // Idle cycle with a disturbing operand: mask must hold.
    task automatic idle(input logic [127:0] op);
        @(negedge clk);
        in_valid = 1'b0;
        in_operand = op;
        @(negedge clk);
        check("R1", XLEN'(out_valid), XLEN'(0));
        check("R10", XLEN'(out_mask), XLEN'(last_exp));
    endtask

    function automatic logic [127:0] rnd_op();
        logic [127:0] r = {$urandom, $urandom, $urandom, $urandom};
        int k = $urandom_range(0, 5);
        case (k)
            0: r[126:112] = '0;
            1: r[126:112] = '1;
            2: begin r[126:112] = '1; r[111:0] = '0; end
            3: begin r[126:112] = '0; r[111:0] = '0; end
            4: begin r[126:112] = '1; r[111] = 1'b0; r[0] = 1'b1; end
            default: ;
        endcase
        return r;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // Reset state with in_valid high during reset (R1).
        in_valid = 1'b1;
        in_operand = mk(1'b0, 15'h3fff, '0);
        repeat (3) @(negedge clk);
        check("R1", XLEN'(out_valid), XLEN'(0));
        check("R1", out_mask, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        for (int s = 0; s < 2; s++) begin
            send(mk(s[0], '1, '0));                        // R4 infinity
            send(mk(s[0], 15'h0001, '0));                  // R5 min normal
            send(mk(s[0], 15'h7ffe, '1));                  // R5 max normal
            send(mk(s[0], '0, 112'h1));                    // R6 min subnormal
            send(mk(s[0], '0, '1));                        // R6 max subnormal
            send(mk(s[0], '0, '0));                        // R7 zero
            send(mk(s[0], '1, {1'b1, 111'h0}));            // R8 bare quiet NaN
            send(mk(s[0], '1, '1));                        // R8 quiet NaN full payload
            send(mk(s[0], '1, 112'h1));                    // R9 minimal signalling NaN
            send(mk(s[0], '1, {1'b0, {111{1'b1}}}));       // R9 max signalling NaN
            idle(mk(1'b1, '1, 112'h5));                    // R10 sNaN offered while idle
        end

        for (int i = 0; i < 3000; i++) begin
            send(rnd_op());
            if ($urandom_range(0, 3) == 0) idle(rnd_op());
        end

        // Mid-run reset clears valid and mask (R1).
        @(negedge clk);
        in_valid = 1'b1;
        in_operand = mk(1'b0, '1, '1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", XLEN'(out_valid), XLEN'(0));
        check("R1", out_mask, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        send(mk(1'b1, 15'h1234, 112'h77));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule